// File: doc/BRIEF.md
# Serial Link Power-State Controller

This block manages the two low-power states of a serial storage link, the partial state and the slumber state. It works on primitives carried as 4-bit tokens. Every cycle it sends one token on a transmit port and reads one token from a receive port. Coding, out-of-band analog detection and speed negotiation belong to neighbouring blocks.

Locally, two level inputs ask for partial or slumber. The block holds such a request until the link is not carrying a frame, then repeats the matching power-request token until the far end accepts or refuses it. If no answer arrives within a parameterised number of cycles, the block gives up and returns to idle.

A power request from the far end is answered according to a policy input: accept when power-down is allowed, refuse otherwise. Leaving sleep works in either direction. A local wake input produces a one-cycle wake pulse. A far-end wake detect input produces a one-cycle wake-recovered flag. In both cases the block then sends ALIGN tokens until the far end answers with ALIGN, and only then clears its sleeping output.

Top module: `link_pwr_ctrl`

## Requirements
- R1: After reset the transmit token is SYNC (code 0) and the sleeping, slumber, wake-pulse and wake-recovered outputs are all low.
- R2: A local partial or slumber request sends a power-request token (partial code 2, slumber code 3) one cycle after the edge at which the request is seen with `link_busy` low. While `link_busy` is high the block keeps sending SYNC.
- R3: When the local partial and slumber inputs are both high, the slumber request (code 3) is sent.
- R4: A local power request repeats every cycle. Receiving accept (code 4) enters sleep on the next cycle. Receiving refuse (code 5) returns to SYNC with the sleeping output still low.
- R5: With no answer, the power request is sent for exactly `REQ_TIMEOUT` cycles, followed by SYNC.
- R6: A far-end power request (code 2 or 3) seen while idle is answered with accept (code 4) when `allow_pd` is high, or with refuse (code 5) when it is low. The answer is sent for `ACK_REPS` cycles. After a refuse the block returns to SYNC.
- R7: The sleeping output rises only after an accept, and the transmit token is QUIET (code 6) while asleep. The slumber output is high during sleep only when the state entered was slumber.
- R8: While asleep, a high `wake_req` makes `wake_pulse` high for exactly one cycle. From that cycle the block sends ALIGN (code 1).
- R9: While asleep, a high `wake_det` makes `wake_recov` high for exactly one cycle and starts sending ALIGN. If both wake inputs are high together, the far-end wake is the one taken.
- R10: After a wake, the block keeps sending ALIGN with the sleeping output high until ALIGN (code 1) is received. The cycle after that, it sends SYNC with the sleeping and slumber outputs low.
- R11: While asleep, the local partial and slumber inputs have no effect: the output stays QUIET and the sleeping output stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| part_go | input | 1 | Level request to enter partial |
| slum_go | input | 1 | Level request to enter slumber |
| allow_pd | input | 1 | Policy: accept far-end power requests when high |
| link_busy | input | 1 | High while a frame is in progress on the link |
| wake_req | input | 1 | Local wake request |
| wake_det | input | 1 | Far-end wake signal detected |
| rx_tok | input | 4 | Received primitive token |
| tx_tok | output | 4 | Transmitted primitive token |
| asleep | output | 1 | Link is in a low-power state |
| slumber | output | 1 | The low-power state is slumber |
| wake_pulse | output | 1 | One-cycle request to emit the wake signal |
| wake_recov | output | 1 | One-cycle flag: woken by the far end |

## Verification
The bench builds the block with `REQ_TIMEOUT` = 8 and `ACK_REPS` = 3. This makes the give-up window short enough that every cycle of an unanswered request can be counted. It also makes the accept and refuse bursts short enough that their exact end cycles can be checked. The scenarios cover local and far-end entry into both states, refusal on each side, wake from each side, and request inputs held during a frame and during sleep.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

    typedef enum logic [3:0] {
        TK_SYNC   = 4'd0,
        TK_ALIGN  = 4'd1,
        TK_PREQ_P = 4'd2,
        TK_PREQ_S = 4'd3,
        TK_PACK   = 4'd4,
        TK_PNAK   = 4'd5,
        TK_QUIET  = 4'd6,
        TK_DATA   = 4'd7
    } tok_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_ACK,
        ST_NAK,
        ST_SLEEP,
        ST_WAKE
    } lpc_state_t;

endpackage

// File: rtl/lpc_req_decode.sv
module lpc_req_decode
    import lpc_pkg::*;
(
    input  logic [3:0] rx_tok,
    input  logic       part_go,
    input  logic       slum_go,
    input  logic       link_busy,
    output logic       far_req,
    output logic       far_slum,
    output logic       loc_req,
    output logic       loc_slum
);
    always_comb begin
        far_req  = (rx_tok == TK_PREQ_P) || (rx_tok == TK_PREQ_S);
        far_slum = (rx_tok == TK_PREQ_S);
        // local requests only at an idle point of the link
        loc_req  = (part_go || slum_go) && !link_busy;
        // slumber wins over partial
        loc_slum = slum_go;
    end
endmodule

// File: rtl/lpc_cycle_cnt.sv
module lpc_cycle_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] lim,
    output logic         at_lim
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr)
            cnt_d = '0;
        else if (cnt_q == lim)
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign at_lim = (cnt_q == lim);

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cnt_q != lim) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/link_pwr_ctrl.sv
module link_pwr_ctrl
    import lpc_pkg::*;
#(
    parameter int REQ_TIMEOUT = 1024,
    parameter int ACK_REPS    = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       part_go,
    input  logic       slum_go,
    input  logic       allow_pd,
    input  logic       link_busy,
    input  logic       wake_req,
    input  logic       wake_det,
    input  logic [3:0] rx_tok,
    output logic [3:0] tx_tok,
    output logic       asleep,
    output logic       slumber,
    output logic       wake_pulse,
    output logic       wake_recov
);
    localparam int MAXC = (REQ_TIMEOUT > ACK_REPS) ? REQ_TIMEOUT : ACK_REPS;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] TMO_LIM = CW'(REQ_TIMEOUT - 1);
    localparam logic [CW-1:0] REP_LIM = CW'(ACK_REPS - 1);

    typedef struct packed {
        lpc_state_t st;
        tok_t       tx;
        logic       md;
        logic       slp;
        logic       slm;
        logic       ws;
        logic       wr;
    } regs_t;

    regs_t r_d, r_q;
    logic  far_req, far_slum, loc_req, loc_slum;
    logic  cnt_clr, at_lim;
    logic [CW-1:0] lim;

    lpc_req_decode u_dec (
        .rx_tok    (rx_tok),
        .part_go   (part_go),
        .slum_go   (slum_go),
        .link_busy (link_busy),
        .far_req   (far_req),
        .far_slum  (far_slum),
        .loc_req   (loc_req),
        .loc_slum  (loc_slum)
    );

    lpc_cycle_cnt #(.W(CW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cnt_clr),
        .lim    (lim),
        .at_lim (at_lim)
    );

    assign lim = (r_q.st == ST_REQ) ? TMO_LIM : REP_LIM;

    always_comb begin
        r_d    = r_q;
        r_d.ws = 1'b0;
        r_d.wr = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                r_d.tx = TK_SYNC;
                if (far_req) begin
                    r_d.md = far_slum;
                    if (allow_pd) begin
                        r_d.st = ST_ACK;
                        r_d.tx = TK_PACK;
                    end else begin
                        r_d.st = ST_NAK;
                        r_d.tx = TK_PNAK;
                    end
                end else if (loc_req) begin
                    r_d.st = ST_REQ;
                    r_d.md = loc_slum;
                    r_d.tx = loc_slum ? TK_PREQ_S : TK_PREQ_P;
                end
            end
            ST_REQ: begin
                if (rx_tok == TK_PACK) begin
                    r_d.st  = ST_SLEEP;
                    r_d.tx  = TK_QUIET;
                    r_d.slp = 1'b1;
                    r_d.slm = r_q.md;
                end else if (rx_tok == TK_PNAK || at_lim) begin
                    r_d.st = ST_IDLE;
                    r_d.tx = TK_SYNC;
                end
            end
            ST_ACK: begin
                if (at_lim) begin
                    r_d.st  = ST_SLEEP;
                    r_d.tx  = TK_QUIET;
                    r_d.slp = 1'b1;
                    r_d.slm = r_q.md;
                end
            end
            ST_NAK: begin
                if (at_lim) begin
                    r_d.st = ST_IDLE;
                    r_d.tx = TK_SYNC;
                end
            end
            ST_SLEEP: begin
                if (wake_det) begin
                    r_d.st = ST_WAKE;
                    r_d.tx = TK_ALIGN;
                    r_d.wr = 1'b1;
                end else if (wake_req) begin
                    r_d.st = ST_WAKE;
                    r_d.tx = TK_ALIGN;
                    r_d.ws = 1'b1;
                end
            end
            ST_WAKE: begin
                if (rx_tok == TK_ALIGN) begin
                    r_d.st  = ST_IDLE;
                    r_d.tx  = TK_SYNC;
                    r_d.slp = 1'b0;
                    r_d.slm = 1'b0;
                end
            end
            default: begin
                r_d.st = ST_IDLE;
                r_d.tx = TK_SYNC;
            end
        endcase
        cnt_clr = (r_d.st != r_q.st);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= ST_IDLE;
            r_q.tx  <= TK_SYNC;
            r_q.md  <= 1'b0;
            r_q.slp <= 1'b0;
            r_q.slm <= 1'b0;
            r_q.ws  <= 1'b0;
            r_q.wr  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_tok     = r_q.tx;
    assign asleep     = r_q.slp;
    assign slumber    = r_q.slm;
    assign wake_pulse = r_q.ws;
    assign wake_recov = r_q.wr;

    logic tx_is_preq;
    assign tx_is_preq = (tx_tok == TK_PREQ_P) || (tx_tok == TK_PREQ_S);

    // R2
    preq_idle_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_is_preq) |-> !$past(link_busy));

    // R3
    slum_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && !far_req && part_go && slum_go && !link_busy)
            |=> (tx_tok == TK_PREQ_S));

    // R5
    req_giveup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_REQ && at_lim && rx_tok != TK_PACK && rx_tok != TK_PNAK)
            |=> (tx_tok == TK_SYNC && !asleep));

    // R6
    far_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && far_req && !allow_pd) |=> (tx_tok == TK_PNAK));

    // R7
    sleep_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(asleep) |-> ($past(rx_tok) == TK_PACK || $past(tx_tok) == TK_PACK));

    // R9
    recov_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_recov) |-> ($past(wake_det) && $past(asleep)));

    // R10
    wake_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(asleep) |-> ($past(rx_tok) == TK_ALIGN));

    // R8
    wake_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);
endmodule

// File: tb/link_pwr_ctrl_test.sv
`timescale 1ns/1ps
module link_pwr_ctrl_test;
    localparam int TMO  = 8;
    localparam int REPS = 3;
    localparam logic [3:0] SYNC = 4'd0, ALGN = 4'd1, PRP = 4'd2, PRS = 4'd3,
                           ACK = 4'd4, NAK = 4'd5, QUI = 4'd6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic part_go = 0, slum_go = 0, allow_pd = 0, link_busy = 0;
    logic wake_req = 0, wake_det = 0;
    logic [3:0] rx_tok = 4'd0;
    logic [3:0] tx_tok;
    logic asleep, slumber, wake_pulse, wake_recov;

    always #2.5 clk = ~clk;

    link_pwr_ctrl #(.REQ_TIMEOUT(TMO), .ACK_REPS(REPS)) uut (
        .clk(clk), .rst_n(rst_n), .part_go(part_go), .slum_go(slum_go),
        .allow_pd(allow_pd), .link_busy(link_busy), .wake_req(wake_req),
        .wake_det(wake_det), .rx_tok(rx_tok), .tx_tok(tx_tok), .asleep(asleep),
        .slumber(slumber), .wake_pulse(wake_pulse), .wake_recov(wake_recov)
    );

    typedef struct {
        int         cyc;
        logic [3:0] tx;
        logic       slp, slm, ws, wr;
        string      tag;
    } exp_t;

    exp_t q[$];
    int cyc = 0;
    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // driver side: push an expectation d cycles ahead
    task automatic expect_at(input int d, input logic [3:0] t, input logic s,
                             input logic m, input logic w, input logic r,
                             input string tag);
        exp_t e;
        e.cyc = cyc + d; e.tx = t; e.slp = s; e.slm = m; e.ws = w; e.wr = r;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: compare outputs against due expectations
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].cyc == cyc) begin
            exp_t e;
            e = q.pop_front();
            nchk++;
            if (tx_tok !== e.tx || asleep !== e.slp || slumber !== e.slm ||
                wake_pulse !== e.ws || wake_recov !== e.wr) begin
                nfail++;
                $display("FAIL %s cyc=%0d: tx=%0d slp=%b slm=%b ws=%b wr=%b expected tx=%0d slp=%b slm=%b ws=%b wr=%b",
                         e.tag, cyc, tx_tok, asleep, slumber, wake_pulse, wake_recov,
                         e.tx, e.slp, e.slm, e.ws, e.wr);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        expect_at(1, SYNC, 0, 0, 0, 0, "R1 reset");
        tick(2);

        // R2: request held during a frame
        part_go = 1; link_busy = 1;
        for (int k = 1; k <= 3; k++) expect_at(k, SYNC, 0, 0, 0, 0, "R2 held busy");
        tick(3);
        link_busy = 0;
        expect_at(1, PRP, 0, 0, 0, 0, "R2 partial sent");
        tick(1);
        rx_tok = ACK; part_go = 0;
        expect_at(1, QUI, 1, 0, 0, 0, "R4 R7 accept to partial");
        tick(1);
        rx_tok = SYNC;

        // R11: go inputs ignored while asleep
        part_go = 1; slum_go = 1;
        for (int k = 1; k <= 3; k++) expect_at(k, QUI, 1, 0, 0, 0, "R11 ignore go");
        tick(3);
        part_go = 0; slum_go = 0;
        tick(1);

        // R8: local wake
        wake_req = 1;
        expect_at(1, ALGN, 1, 0, 1, 0, "R8 wake pulse");
        tick(1);
        wake_req = 0;
        expect_at(1, ALGN, 1, 0, 0, 0, "R8 pulse one cycle");
        expect_at(2, ALGN, 1, 0, 0, 0, "R10 wait align");
        tick(2);
        rx_tok = ALGN;
        expect_at(1, SYNC, 0, 0, 0, 0, "R10 back to idle");
        tick(1);
        rx_tok = SYNC;
        tick(1);

        // R3 priority then R4 refuse
        part_go = 1; slum_go = 1;
        expect_at(1, PRS, 0, 0, 0, 0, "R3 slumber wins");
        tick(1);
        rx_tok = NAK; part_go = 0; slum_go = 0;
        expect_at(1, SYNC, 0, 0, 0, 0, "R4 refused");
        expect_at(2, SYNC, 0, 0, 0, 0, "R4 stays idle");
        tick(1);
        rx_tok = SYNC;
        tick(2);

        // R5: timeout
        part_go = 1;
        expect_at(1, PRP, 0, 0, 0, 0, "R5 first request");
        tick(1);
        part_go = 0;
        for (int k = 1; k < TMO; k++) expect_at(k, PRP, 0, 0, 0, 0, "R4 R5 repeating");
        expect_at(TMO, SYNC, 0, 0, 0, 0, "R5 give up");
        tick(TMO + 1);

        // R6: far-end request refused
        allow_pd = 0; rx_tok = PRS;
        for (int k = 1; k <= REPS; k++) expect_at(k, NAK, 0, 0, 0, 0, "R6 refuse");
        expect_at(REPS + 1, SYNC, 0, 0, 0, 0, "R6 refuse ends");
        tick(1);
        rx_tok = SYNC;
        tick(REPS + 1);

        // R6 R7: far-end slumber accepted
        allow_pd = 1; rx_tok = PRS;
        for (int k = 1; k <= REPS; k++) expect_at(k, ACK, 0, 0, 0, 0, "R6 accept");
        expect_at(REPS + 1, QUI, 1, 1, 0, 0, "R7 asleep slumber");
        tick(1);
        rx_tok = SYNC;
        tick(REPS + 1);

        // R9: far-end wake, both wakes at once
        wake_det = 1; wake_req = 1;
        expect_at(1, ALGN, 1, 1, 0, 1, "R9 wake recovered");
        tick(1);
        wake_det = 0; wake_req = 0;
        expect_at(1, ALGN, 1, 1, 0, 0, "R9 flag one cycle");
        tick(1);
        rx_tok = ALGN;
        expect_at(1, SYNC, 0, 0, 0, 0, "R10 idle after align");
        tick(1);
        rx_tok = SYNC;
        tick(3);

        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            nchk++; nfail++;
            $display("FAIL %s: actual=unchecked expected=checked at cyc %0d", e.tag, e.cyc);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule